// File: doc/BRIEF.md
# Prioritised Interrupt Requester with Acknowledge Chain

This block lets one board on a shared backplane raise an interrupt and then answer for it. A local event sets a pending request, and the block pulls low one of seven shared, active-low request lines. The line it uses is chosen by a programmable level register. A handler elsewhere on the bus answers with an acknowledge cycle. That cycle carries the level it is serving on three address bits. A grant token runs from board to board along a daisy chain.

When the token reaches this block, the block checks the acknowledged level. If it has a pending request at that level, it keeps the token. It then presents its programmed 8-bit identification vector on the data bus and pulls its transfer-acknowledge output low until the data strobe goes high. In every other case it hands the token on downstream, so the board nearest the handler wins among boards that share a level.

The request is released when the acknowledge finishes. Local events that arrive before the address strobe goes high again are dropped. All bus inputs are assumed to be synchronous to the block clock.

Top module: `intr_chain_node`

## Requirements
- R1: While reset is held, and right after it, every request line is high (released), the downstream chain output is high, the acknowledge output is high and the vector output is not enabled, with the vector bus at zero.
- R2: With the level register at L (1 to 7), a local event pulls request line L low in the cycle after the event edge. Line L is bit L-1 of the active-low request vector. The line stays low until that request is acknowledged. No more than one line is ever low.
- R3: With the level register at 0, a local event drives no request line. The block never claims an acknowledge cycle, and it passes the chain token on.
- R4: In an acknowledge cycle the acknowledge-cycle, address-strobe, data-strobe and chain inputs are all low. If the block is not pending, or the acknowledged level differs from its level, it drives the chain output low from the next edge and leaves the acknowledge output high.
- R5: In such a cycle, if the block is pending at the acknowledged level, it keeps the chain output high. From the next edge it drives the acknowledge output low, enables the vector output and puts the programmed vector on it, and it holds this until the data strobe is high.
- R6: At the first edge where the data strobe is high while the block is acknowledging, it releases the acknowledge output, disables the vector and releases its request line, all at that edge.
- R7: After an acknowledge, local events are ignored until an edge sees the address strobe high. The ignored events leave the request lines released.
- R8: The chain output goes high in the same cycle the chain input goes high, with no clock edge in between.
- R9: While the chain input is high, the block neither claims an acknowledge cycle nor drives the chain output low, even when its own level is the one being acknowledged.
- R10: A configuration write sets the level and vector registers at the next edge. The vector shown during an acknowledge is the last vector written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 1 | Local event that raises a request |
| cfg_wr_i | input | 1 | Write enable for the level and vector registers |
| cfg_level_i | input | 3 | Request level to store (0 disables requesting) |
| cfg_vector_i | input | 8 | Identification vector to store |
| ack_cycle_n_i | input | 1 | Active-low marker of an interrupt-acknowledge cycle |
| addr_strobe_n_i | input | 1 | Active-low address strobe |
| data_strobe_n_i | input | 1 | Active-low data strobe |
| ack_level_i | input | 3 | Level being acknowledged (address bits 3 to 1) |
| chain_in_n_i | input | 1 | Active-low grant token from upstream |
| chain_out_n_o | output | 1 | Active-low grant token to downstream |
| req_lines_n_o | output | 7 | Active-low request lines, bit i is level i+1 |
| resp_ack_n_o | output | 1 | Active-low transfer acknowledge |
| vector_o | output | 8 | Identification vector, zero when not enabled |
| vector_oe_o | output | 1 | Enable for the vector onto the data bus |

## Verification
The properties take it as given that the handler drives a well-formed acknowledge cycle. The address strobe falls no later than the data strobe, the data strobe rises no later than the address strobe, and the upstream token goes low only while both strobes are low. The bench keeps to this order. It changes the strobes, the level bits and the token only after a falling clock edge and never glitches the strobes inside a cycle. It also separates configuration writes from local events by at least one cycle, so each request is raised at a known level.

// File: rtl/intr_chain_pkg.sv
package intr_chain_pkg;

  // Phases of the acknowledge-chain sequencer
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for a chained acknowledge cycle
    ST_PASS  = 2'd1,  // token handed downstream
    ST_SERVE = 2'd2,  // this node owns the cycle
    ST_REARM = 2'd3   // waiting for address strobe to rise
  } ack_state_e;

endpackage

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic [VEC_W-1:0] vec_in,
  output logic [LVL_W-1:0] lvl_q,
  output logic [VEC_W-1:0] vec_q
);

  logic [LVL_W-1:0] lvl_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    lvl_d = lvl_q;
    vec_d = vec_q;
    if (wr_en) begin
      lvl_d = lvl_in;
      vec_d = vec_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

endmodule

// File: rtl/intr_req_track.sv
module intr_req_track #(
  parameter int LEVELS = 7,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              arm_ok,
  input  logic              clr,
  input  logic [LVL_W-1:0]  lvl,
  output logic              pend_q,
  output logic [LEVELS-1:0] lines_n
);

  logic pend_d;
  logic lvl_on;

  assign lvl_on = (lvl != '0);

  // Clearing on acknowledge wins over a new event in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (clr) begin
      pend_d = 1'b0;
    end else if (evt && arm_ok && lvl_on) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // One decoder slice per shared request line
  for (genvar i = 0; i < LEVELS; i++) begin : g_line
    assign lines_n[i] = !(pend_q && (lvl == LVL_W'(i + 1)));
  end

endmodule

// File: rtl/intr_ack_fsm.sv
module intr_ack_fsm
  import intr_chain_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_cyc_n,
  input  logic             as_n,
  input  logic             ds_n,
  input  logic             chain_in_n,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic [LVL_W-1:0] own_lvl,
  input  logic             pend,
  output logic             chain_out_n,
  output logic             resp_ack_n,
  output logic             serving,
  output logic             arm_ok,
  output logic             clr
);

  ack_state_e state_q, state_d;
  logic       cyc_live;
  logic       lvl_hit;

  assign cyc_live = !ack_cyc_n && !as_n && !ds_n && !chain_in_n;
  assign lvl_hit  = pend && (own_lvl != '0) && (ack_lvl == own_lvl);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cyc_live) begin
          state_d = lvl_hit ? ST_SERVE : ST_PASS;
        end
      end
      ST_PASS: begin
        if (chain_in_n || as_n) begin
          state_d = ST_IDLE;
        end
      end
      ST_SERVE: begin
        if (ds_n || as_n) begin
          state_d = ST_REARM;
        end
      end
      ST_REARM: begin
        if (as_n) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Token drops as soon as upstream lets go, with no edge in between
  assign chain_out_n = (state_q != ST_PASS) || chain_in_n;
  assign resp_ack_n  = (state_q != ST_SERVE);
  assign serving     = (state_q == ST_SERVE);
  assign arm_ok      = (state_q != ST_REARM) && (state_d != ST_REARM);
  assign clr         = (state_q == ST_SERVE) && (state_d == ST_REARM);

endmodule

// File: rtl/intr_chain_node.sv
module intr_chain_node #(
  parameter  int LEVELS = 7,
  parameter  int VEC_W  = 8,
  localparam int LVL_W  = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              cfg_wr_i,
  input  logic [LVL_W-1:0]  cfg_level_i,
  input  logic [VEC_W-1:0]  cfg_vector_i,
  input  logic              ack_cycle_n_i,
  input  logic              addr_strobe_n_i,
  input  logic              data_strobe_n_i,
  input  logic [LVL_W-1:0]  ack_level_i,
  input  logic              chain_in_n_i,
  output logic              chain_out_n_o,
  output logic [LEVELS-1:0] req_lines_n_o,
  output logic              resp_ack_n_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              vector_oe_o
);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic             pend;
  logic             arm_ok;
  logic             clr;
  logic             serving;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  intr_cfg_regs #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (cfg_wr_i),
    .lvl_in (cfg_level_i),
    .vec_in (cfg_vector_i),
    .lvl_q  (lvl_q),
    .vec_q  (vec_q)
  );

  intr_req_track #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_req (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt     (evt_i),
    .arm_ok  (arm_ok),
    .clr     (clr),
    .lvl     (lvl_q),
    .pend_q  (pend),
    .lines_n (req_lines_n_o)
  );

  intr_ack_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ack_cyc_n   (ack_cycle_n_i),
    .as_n        (addr_strobe_n_i),
    .ds_n        (data_strobe_n_i),
    .chain_in_n  (chain_in_n_i),
    .ack_lvl     (ack_level_i),
    .own_lvl     (lvl_q),
    .pend        (pend),
    .chain_out_n (chain_out_n_o),
    .resp_ack_n  (resp_ack_n_o),
    .serving     (serving),
    .arm_ok      (arm_ok),
    .clr         (clr)
  );

  assign vector_oe_o = serving;
  assign vector_o    = serving ? vec_q : '0;

endmodule

// File: rtl/intr_chain_node_chk.sv
module intr_chain_node_chk #(
  parameter int LEVELS = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chain_in_n_i,
  input logic              chain_out_n_o,
  input logic              resp_ack_n_o,
  input logic              data_strobe_n_i,
  input logic              vector_oe_o,
  input logic [LEVELS-1:0] req_lines_n_o
);

  // R5
  claim_keeps_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_ack_n_o |-> chain_out_n_o);

  // R5
  claim_drives_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_ack_n_o |-> vector_oe_o);

  // R8
  token_follows_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_in_n_i |-> chain_out_n_o);

  // R6
  ack_ends_on_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_ack_n_o && data_strobe_n_i) |=> (resp_ack_n_o && !vector_oe_o && (&req_lines_n_o)));

  // R2
  single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~req_lines_n_o) <= 1);

  // R9
  claim_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resp_ack_n_o) |-> !$past(chain_in_n_i));

endmodule

bind intr_chain_node intr_chain_node_chk #(.LEVELS(LEVELS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .chain_in_n_i    (chain_in_n_i),
  .chain_out_n_o   (chain_out_n_o),
  .resp_ack_n_o    (resp_ack_n_o),
  .data_strobe_n_i (data_strobe_n_i),
  .vector_oe_o     (vector_oe_o),
  .req_lines_n_o   (req_lines_n_o)
);

// File: tb/intr_chain_node_test.sv
module intr_chain_node_test;

  logic       clk;
  logic       rst_n;
  logic       evt, cfg_wr;
  logic [2:0] cfg_lvl;
  logic [7:0] cfg_vec;
  logic       ack_n, as_n, ds_n, cin_n;
  logic [2:0] lva;
  logic       cout_n, rack_n, voe;
  logic [6:0] lines_n;
  logic [7:0] vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    logic [6:0] lines;
    logic       co;
    logic       ak;
    logic       oe;
    logic [7:0] v;
  } exp_t;

  exp_t q[$];

  intr_chain_node uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_i           (evt),
    .cfg_wr_i        (cfg_wr),
    .cfg_level_i     (cfg_lvl),
    .cfg_vector_i    (cfg_vec),
    .ack_cycle_n_i   (ack_n),
    .addr_strobe_n_i (as_n),
    .data_strobe_n_i (ds_n),
    .ack_level_i     (lva),
    .chain_in_n_i    (cin_n),
    .chain_out_n_o   (cout_n),
    .req_lines_n_o   (lines_n),
    .resp_ack_n_o    (rack_n),
    .vector_o        (vec),
    .vector_oe_o     (voe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [6:0] lmask(int l);
    logic [6:0] m;
    m = 7'h7F;
    m[l-1] = 1'b0;
    return m;
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Driver side: expected outputs after the next rising edge
  task automatic expect_out(string tag, logic [6:0] l, logic co, logic ak,
                            logic oe, logic [7:0] v);
    exp_t e;
    e.tag = tag; e.lines = l; e.co = co; e.ak = ak; e.oe = oe; e.v = v;
    q.push_back(e);
  endtask

  // Monitor side: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({lines_n, cout_n, rack_n, voe, vec} !== {e.lines, e.co, e.ak, e.oe, e.v}) begin
          fails++;
          $display("FAIL %s: got lines=%h co=%b ack=%b oe=%b vec=%h, expected lines=%h co=%b ack=%b oe=%b vec=%h",
                   e.tag, lines_n, cout_n, rack_n, voe, vec, e.lines, e.co, e.ak, e.oe, e.v);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = 0; cfg_wr = 0; cfg_lvl = 0; cfg_vec = 0;
    ack_n = 1; as_n = 1; ds_n = 1; cin_n = 1; lva = 0;
    tick();
    expect_out("R1 in reset", 7'h7F, 1, 1, 0, 8'h00);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    expect_out("R1 after reset", 7'h7F, 1, 1, 0, 8'h00);

    // Level 3, vector A5
    tick(); cfg_wr = 1; cfg_lvl = 3; cfg_vec = 8'hA5;
    expect_out("R10 write", 7'h7F, 1, 1, 0, 8'h00);
    tick(); cfg_wr = 0; evt = 1;
    expect_out("R2 raise L3", lmask(3), 1, 1, 0, 8'h00);
    tick(); evt = 0;
    expect_out("R2 hold L3", lmask(3), 1, 1, 0, 8'h00);

    // Acknowledge at another level: pass
    tick(); ack_n = 0; as_n = 0; ds_n = 0; cin_n = 0; lva = 5;
    expect_out("R4 pass mismatch", lmask(3), 0, 1, 0, 8'h00);
    tick(); cin_n = 1;
    #0.5;
    checks++;
    if (cout_n !== 1'b1) begin
      fails++;
      $display("FAIL R8 same-cycle release: got %b expected 1", cout_n);
    end
    expect_out("R8 released", lmask(3), 1, 1, 0, 8'h00);
    tick(); ack_n = 1; as_n = 1; ds_n = 1;
    expect_out("R2 still pending", lmask(3), 1, 1, 0, 8'h00);

    // Matching level but no token
    tick(); ack_n = 0; as_n = 0; ds_n = 0; lva = 3; cin_n = 1;
    expect_out("R9 no token", lmask(3), 1, 1, 0, 8'h00);
    tick(); cin_n = 0;
    expect_out("R5 claim", lmask(3), 1, 0, 1, 8'hA5);
    tick();
    expect_out("R5 hold claim", lmask(3), 1, 0, 1, 8'hA5);
    tick(); ds_n = 1;
    expect_out("R6 end", 7'h7F, 1, 1, 0, 8'h00);
    tick(); evt = 1;
    expect_out("R7 event dropped", 7'h7F, 1, 1, 0, 8'h00);
    tick(); evt = 0; as_n = 1; ack_n = 1; cin_n = 1;
    expect_out("R7 rearm", 7'h7F, 1, 1, 0, 8'h00);
    tick();
    expect_out("R7 nothing pending", 7'h7F, 1, 1, 0, 8'h00);

    // Level 7, vector 3C
    tick(); cfg_wr = 1; cfg_lvl = 7; cfg_vec = 8'h3C;
    expect_out("R10 rewrite", 7'h7F, 1, 1, 0, 8'h00);
    tick(); cfg_wr = 0; evt = 1;
    expect_out("R2 raise L7", lmask(7), 1, 1, 0, 8'h00);
    tick(); evt = 0; ack_n = 0; as_n = 0; ds_n = 0; lva = 7; cin_n = 0;
    expect_out("R10 new vector", lmask(7), 1, 0, 1, 8'h3C);
    tick(); ds_n = 1;
    expect_out("R6 end L7", 7'h7F, 1, 1, 0, 8'h00);
    tick(); as_n = 1; ack_n = 1; cin_n = 1;
    expect_out("R7 idle", 7'h7F, 1, 1, 0, 8'h00);

    // Level 0 disables requesting
    tick(); cfg_wr = 1; cfg_lvl = 0;
    expect_out("R3 write 0", 7'h7F, 1, 1, 0, 8'h00);
    tick(); cfg_wr = 0; evt = 1;
    expect_out("R3 no line", 7'h7F, 1, 1, 0, 8'h00);
    tick(); evt = 0; ack_n = 0; as_n = 0; ds_n = 0; lva = 0; cin_n = 0;
    expect_out("R3 passes", 7'h7F, 0, 1, 0, 8'h00);
    tick(); ack_n = 1; as_n = 1; ds_n = 1; cin_n = 1;
    expect_out("R3 idle", 7'h7F, 1, 1, 0, 8'h00);

    tick();
    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule